// File: doc/BRIEF.md
# Strobed External Control Register Bank

This block is the receiving end of a narrow parallel host bus that sets up an audio board's front end. A shared 8-bit data bus, an active-low output enable, a read/write direction line and three active-low per-register strobes load three 8-bit control registers. The system register holds relay, phantom-supply, mute, input-source and codec-run bits. The monitor register holds six routing enables. The clock register holds the sample-rate and sync-source setup.

All bus control lines arrive asynchronously. They pass through two-flop synchronisers, and a register loads when the synchronised strobe shows a low-to-high transition. The host is expected to hold the data bus steady across the whole strobe pulse. The bank decodes the clock register into a rate code, a sync-source flag, an external clock type and three source selects. It raises error flags for the input 1/2 source encoding and for clock encodings that are not allowed.

Top module: `ext_ctl_regbank`

## Requirements
- R1: After reset all three registers read 0x00, so every decoded output is 0, including both error flags.
- R2: When a strobe returns high after being low, the selected register takes the data bus value. The strobes are `stb_n[0]` for system, `stb_n[1]` for monitor and `stb_n[2]` for clock. The register changes within 6 clock cycles of the rising strobe, and only if `oe_n` is low and `rd_wr` is 0 (write).
- R3: A strobe pulse while `oe_n` is high leaves every register unchanged.
- R4: A strobe pulse while `rd_wr` is 1 (read) leaves every register unchanged.
- R5: A strobe pulse changes only its own register. The other two keep their values.
- R6: A strobe held low does not load. The value loaded is the bus value present when the strobe returns high.
- R7: `src12_err` is 1 exactly when system register bits [5:4] equal 2'b10. The legal values are 00 for line, 01 for mic and 11 for mic with low-cut.
- R8: With clock register bit3 = 0 (internal sync), `sync_ext` = 0 and `ext_type` = 0, and bit4 is ignored. Bits [2:0] values 0 to 5 appear on `rate_code` with `clk_err` = 0; these stand for 44.1k, 48k, 88.2k, 96k, 176.4k and 192k. Values 6 and 7 give `rate_code` = 0 and `clk_err` = 1.
- R9: With bit3 = 1 (external sync), `sync_ext` = 1 and `rate_code` = 0. The value {bit4, bits[2:0]} selects the external clock: 0,000 gives `ext_type` 1 (S/PDIF input); 0,010 gives `ext_type` 2 (word clock 1×fs); 1,010 gives `ext_type` 3 (word clock 256×fs). Any other value gives `ext_type` 0 and `clk_err` = 1.
- R10: Clock register bit5 drives `coax_i2s` (1 = I2S). Bit6 drives `in12_alt` (1 = analog 3/4). Bit7 drives `in34_dig` (1 = digital input). None of these depends on the sync mode.
- R11: `route_en[5:0]` equals monitor register bits [5:0]. The paths, in bit order, are in1/2→mon1/2, in1/2→mon3/4, in3/4→mon1/2, in3/4→mon3/4, out3/4→mon1/2 and out1/2→mon3/4. Bits [7:6] reach no route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Shared host data bus |
| oe_n | input | 1 | Active-low output enable, gates all loads |
| rd_wr | input | 1 | Direction, 0 = write |
| stb_n | input | 3 | Active-low strobes: [0] system, [1] monitor, [2] clock |
| sys_reg | output | 8 | System control register |
| mon_reg | output | 8 | Monitor routing register |
| clk_reg | output | 8 | Clock configuration register |
| route_en | output | 6 | Monitor routing path enables |
| src12_err | output | 1 | Illegal input 1/2 source encoding |
| sync_ext | output | 1 | 1 = external sync source |
| rate_code | output | 3 | Internal sample-rate code |
| ext_type | output | 2 | External clock type, 0 = none |
| clk_err | output | 1 | Illegal clock register encoding |
| coax_i2s | output | 1 | Coax output carries I2S |
| in12_alt | output | 1 | Input 1/2 taken from analog 3/4 |
| in34_dig | output | 1 | Input 3/4 taken from digital input |

## Verification
The bench goes after loads that should not happen. It pulses strobes with output enable high or with the read direction, and it holds a strobe low while the bus changes. A design that loaded on the falling strobe edge, or ignored either gate, would show a changed register. The bench checks that each strobe touches only its own register, so crossed strobe wiring shows up at once. It sweeps all eight internal rate codes, with bit4 toggled, and every legal and several illegal external combinations. A decoder that trusted bit4 under internal sync, accepted 0,010 with 256×fs set, or missed 2'b10 on the input 1/2 source would report a wrong type or a missing error flag.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;
  localparam int DW       = 8;
  localparam int NREG     = 3;
  localparam int IDX_SYS  = 0;
  localparam int IDX_MON  = 1;
  localparam int IDX_CLK  = 2;
  localparam int NROUTE   = 6;
  localparam int RATE_W   = 3;
  localparam int RATE_MAX = 5;

  // clock register field positions (decoded by neighbours)
  localparam int CK_SYNC  = 3;
  localparam int CK_WSEL  = 4;
  localparam int CK_COAX  = 5;
  localparam int CK_IN12  = 6;
  localparam int CK_IN34  = 7;
  // system register input 1/2 source field
  localparam int SY_SRC_LO = 4;

  typedef enum logic [1:0] {
    EXT_NONE  = 2'd0,
    EXT_SPDIF = 2'd1,
    EXT_WC1   = 2'd2,
    EXT_WC256 = 2'd3
  } ext_clk_t;

  typedef logic [DW-1:0] creg_t;
endpackage

// File: rtl/cb_sync.sv
module cb_sync #(
  parameter int           W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= INIT;
      s2_q <= INIT;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/cb_strobe_edge.sv
module cb_strobe_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stb_n,
  output logic [N-1:0] rise
);
  logic [N-1:0] stb_s;
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  cb_sync #(.W(N), .INIT({N{1'b1}})) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (stb_n),
    .q     (stb_s)
  );

  always_comb prev_d = stb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= {N{1'b1}};
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = stb_s[i] & ~prev_q[i];
  end
endmodule

// File: rtl/cb_regbank.sv
module cb_regbank
  import ctlbank_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        rise,
  input  logic                oe_s,
  input  logic                rw_s,
  input  logic [W-1:0]        data,
  output logic [N-1:0][W-1:0] regs
);
  logic [N-1:0][W-1:0] regs_q, regs_d;
  logic [N-1:0]        load_en;
  logic                wr_ok;

  assign wr_ok   = ~oe_s & ~rw_s;
  assign load_en = rise & {N{wr_ok}};

  always_comb begin
    regs_d = regs_q;
    for (int i = 0; i < N; i++) begin
      if (load_en[i]) regs_d[i] = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign regs = regs_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && !oe_s && !rw_s) |=> (regs_q[i] == $past(data)));
    // R3
    oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_s |=> $stable(regs_q[i]));
    // R4
    rw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rw_s |=> $stable(regs_q[i]));
    // R5
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise[i] |=> $stable(regs_q[i]));
  end
endmodule

// File: rtl/cb_decode.sv
module cb_decode
  import ctlbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  creg_t             sys_r,
  input  creg_t             mon_r,
  input  creg_t             clk_r,
  output logic [NROUTE-1:0] route_en,
  output logic              src12_err,
  output logic              sync_ext,
  output logic [RATE_W-1:0] rate_code,
  output ext_clk_t          ext_type,
  output logic              clk_err,
  output logic              coax_i2s,
  output logic              in12_alt,
  output logic              in34_dig
);
  logic [RATE_W-1:0] rate_f;
  logic              wsel;
  logic [1:0]        src12;

  assign route_en  = mon_r[NROUTE-1:0];
  assign src12     = sys_r[SY_SRC_LO +: 2];
  assign src12_err = (src12 == 2'b10);

  assign sync_ext  = clk_r[CK_SYNC];
  assign wsel      = clk_r[CK_WSEL];
  assign rate_f    = clk_r[RATE_W-1:0];
  assign coax_i2s  = clk_r[CK_COAX];
  assign in12_alt  = clk_r[CK_IN12];
  assign in34_dig  = clk_r[CK_IN34];

  always_comb begin
    rate_code = '0;
    ext_type  = EXT_NONE;
    clk_err   = 1'b0;
    if (!sync_ext) begin
      if (rate_f <= RATE_W'(RATE_MAX)) rate_code = rate_f;
      else                             clk_err   = 1'b1;
    end else begin
      unique case ({wsel, rate_f})
        4'b0_000: ext_type = EXT_SPDIF;
        4'b0_010: ext_type = EXT_WC1;
        4'b1_010: ext_type = EXT_WC256;
        default:  clk_err  = 1'b1;
      endcase
    end
  end

  // R9
  err_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_err |-> (ext_type == EXT_NONE));
  // R8
  int_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ext |-> (ext_type == EXT_NONE));
  // R8
  rate_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_ext && !clk_err) |-> (rate_code <= RATE_W'(RATE_MAX)));
  // R9
  ext_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ext |-> (rate_code == '0));
endmodule

// File: rtl/ext_ctl_regbank.sv
module ext_ctl_regbank
  import ctlbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     bus_data,
  input  logic              oe_n,
  input  logic              rd_wr,
  input  logic [NREG-1:0]   stb_n,
  output logic [DW-1:0]     sys_reg,
  output logic [DW-1:0]     mon_reg,
  output logic [DW-1:0]     clk_reg,
  output logic [NROUTE-1:0] route_en,
  output logic              src12_err,
  output logic              sync_ext,
  output logic [RATE_W-1:0] rate_code,
  output logic [1:0]        ext_type,
  output logic              clk_err,
  output logic              coax_i2s,
  output logic              in12_alt,
  output logic              in34_dig
);
  logic                   rst_a_q, rst_b_q, rst_i;
  logic [NREG-1:0]        rise;
  logic [1:0]             ctl_s;
  logic [NREG-1:0][DW-1:0] regs;
  ext_clk_t               ext_e;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end
  assign rst_i = rst_b_q;

  cb_strobe_edge #(.N(NREG)) u_edge (
    .clk   (clk),
    .rst_n (rst_i),
    .stb_n (stb_n),
    .rise  (rise)
  );

  // idle: output disabled, read direction
  cb_sync #(.W(2), .INIT(2'b11)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({oe_n, rd_wr}),
    .q     (ctl_s)
  );

  cb_regbank #(.N(NREG), .W(DW)) u_bank (
    .clk   (clk),
    .rst_n (rst_i),
    .rise  (rise),
    .oe_s  (ctl_s[1]),
    .rw_s  (ctl_s[0]),
    .data  (bus_data),
    .regs  (regs)
  );

  assign sys_reg = regs[IDX_SYS];
  assign mon_reg = regs[IDX_MON];
  assign clk_reg = regs[IDX_CLK];

  cb_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_i),
    .sys_r     (regs[IDX_SYS]),
    .mon_r     (regs[IDX_MON]),
    .clk_r     (regs[IDX_CLK]),
    .route_en  (route_en),
    .src12_err (src12_err),
    .sync_ext  (sync_ext),
    .rate_code (rate_code),
    .ext_type  (ext_e),
    .clk_err   (clk_err),
    .coax_i2s  (coax_i2s),
    .in12_alt  (in12_alt),
    .in34_dig  (in34_dig)
  );

  assign ext_type = ext_e;
endmodule

// File: tb/ext_ctl_regbank_test.sv
module ext_ctl_regbank_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_data;
  logic       oe_n, rd_wr;
  logic [2:0] stb_n;
  logic [7:0] sys_reg, mon_reg, clk_reg;
  logic [5:0] route_en;
  logic       src12_err, sync_ext, clk_err, coax_i2s, in12_alt, in34_dig;
  logic [2:0] rate_code;
  logic [1:0] ext_type;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string      tag;
    logic [7:0] s, m, c;
  } exp_t;
  exp_t sb_q[$];

  logic [7:0] m_sys = 8'h00, m_mon = 8'h00, m_clk = 8'h00;

  always #4 clk = ~clk;

  ext_ctl_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .oe_n(oe_n), .rd_wr(rd_wr),
    .stb_n(stb_n), .sys_reg(sys_reg), .mon_reg(mon_reg), .clk_reg(clk_reg),
    .route_en(route_en), .src12_err(src12_err), .sync_ext(sync_ext),
    .rate_code(rate_code), .ext_type(ext_type), .clk_err(clk_err),
    .coax_i2s(coax_i2s), .in12_alt(in12_alt), .in34_dig(in34_dig)
  );

  // expected decode, from R8/R9 tables
  function automatic logic [1:0] want_ext(logic [7:0] c);
    if (!c[3])                 return 2'd0;
    if (c[4:0] == 5'b01000)    return 2'd1;
    if (c[4:0] == 5'b01010)    return 2'd2;
    if (c[4:0] == 5'b11010)    return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic want_err(logic [7:0] c);
    if (!c[3]) return (c[2:0] == 3'd6) || (c[2:0] == 3'd7);
    return want_ext(c) == 2'd0;
  endfunction

  function automatic logic [2:0] want_rate(logic [7:0] c);
    if (c[3] || want_err(c)) return 3'd0;
    return c[2:0];
  endfunction

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected snapshots and compares ports
  initial begin
    forever begin
      exp_t it;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      cmp(it.tag, "sys_reg", sys_reg, it.s);
      cmp(it.tag, "mon_reg", mon_reg, it.m);
      cmp(it.tag, "clk_reg", clk_reg, it.c);
      cmp({it.tag, "/R11"}, "route_en", {2'b0, route_en}, {2'b0, it.m[5:0]});
      cmp({it.tag, "/R7"}, "src12_err", {7'b0, src12_err}, {7'b0, it.s[5:4] == 2'b10});
      cmp({it.tag, "/R8"}, "sync_ext", {7'b0, sync_ext}, {7'b0, it.c[3]});
      cmp({it.tag, "/R8"}, "rate_code", {5'b0, rate_code}, {5'b0, want_rate(it.c)});
      cmp({it.tag, "/R9"}, "ext_type", {6'b0, ext_type}, {6'b0, want_ext(it.c)});
      cmp({it.tag, "/R9"}, "clk_err", {7'b0, clk_err}, {7'b0, want_err(it.c)});
      cmp({it.tag, "/R10"}, "srcsel", {5'b0, in34_dig, in12_alt, coax_i2s},
          {5'b0, it.c[7:5]});
      #1;
    end
  end

  task automatic push(string tag);
    exp_t it;
    it.tag = tag; it.s = m_sys; it.m = m_mon; it.c = m_clk;
    sb_q.push_back(it);
    @(negedge clk);
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic upd(int idx, logic [7:0] v);
    case (idx)
      0: m_sys = v;
      1: m_mon = v;
      default: m_clk = v;
    endcase
  endtask

  // driver: one strobe pulse, then record expectation
  task automatic xfer(int idx, logic [7:0] v, logic oe, logic rw, string tag);
    bus_data = v; oe_n = oe; rd_wr = rw;
    repeat (2) @(negedge clk);
    stb_n[idx] = 1'b0;
    repeat (3) @(negedge clk);
    stb_n[idx] = 1'b1;
    repeat (6) @(negedge clk);
    if (!oe && !rw) upd(idx, v);
    push(tag);
    oe_n = 1'b1; rd_wr = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; bus_data = 8'h00; oe_n = 1'b1; rd_wr = 1'b1; stb_n = 3'b111;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    push("R1 reset");

    // R2 / R5 / R7 system register
    xfer(0, 8'h20, 1'b0, 1'b0, "R7 src 10");
    xfer(0, 8'h30, 1'b0, 1'b0, "R7 src 11");
    xfer(0, 8'h10, 1'b0, 1'b0, "R2 sys mic");
    xfer(0, 8'hA5, 1'b0, 1'b0, "R7 sys A5");
    // R11 monitor
    xfer(1, 8'hFF, 1'b0, 1'b0, "R11 mon FF");
    xfer(1, 8'h15, 1'b0, 1'b0, "R5 mon 15");
    // R8 internal rates, bit4 toggled
    for (int r = 0; r < 8; r++) begin
      xfer(2, 8'(r) | ((r % 2 == 1) ? 8'h10 : 8'h00), 1'b0, 1'b0, "R8 rate");
    end
    // R9 external legal and illegal
    xfer(2, 8'h08, 1'b0, 1'b0, "R9 spdif");
    xfer(2, 8'h0A, 1'b0, 1'b0, "R9 wc1");
    xfer(2, 8'h1A, 1'b0, 1'b0, "R9 wc256");
    xfer(2, 8'h18, 1'b0, 1'b0, "R9 bad 1000");
    xfer(2, 8'h09, 1'b0, 1'b0, "R9 bad 0001");
    xfer(2, 8'h0B, 1'b0, 1'b0, "R9 bad 0011");
    xfer(2, 8'h1F, 1'b0, 1'b0, "R9 bad 1111");
    // R10 source selects under both sync modes
    xfer(2, 8'hA8, 1'b0, 1'b0, "R10 ext A8");
    xfer(2, 8'h63, 1'b0, 1'b0, "R10 int 63");
    // R3 / R4 blocked writes
    xfer(2, 8'h5A, 1'b1, 1'b0, "R3 oe high");
    xfer(0, 8'hC3, 1'b1, 1'b0, "R3 oe high sys");
    xfer(1, 8'h3C, 1'b0, 1'b1, "R4 read dir");
    xfer(2, 8'h0A, 1'b0, 1'b1, "R4 read dir clk");

    // R6 strobe held low: no load until it returns high
    bus_data = 8'h11; oe_n = 1'b0; rd_wr = 1'b0;
    repeat (2) @(negedge clk);
    stb_n[1] = 1'b0;
    repeat (8) @(negedge clk);
    push("R6 held low");
    bus_data = 8'h2A;
    repeat (3) @(negedge clk);
    stb_n[1] = 1'b1;
    repeat (6) @(negedge clk);
    upd(1, 8'h2A);
    push("R6 rise value");
    oe_n = 1'b1; rd_wr = 1'b1;

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule